// File: doc/BRIEF.md
# DRAM Parallel-Test Compression Model

This block is a synthesizable, scaled-down behavioural model of an asynchronous multiplexed-address DRAM. It is meant to sit in a simulation next to a memory controller under test. It samples the row strobe, column strobe, write enable, the shared address bus and the data-in bus on a fast system clock, and finds strobe edges by comparing each sample with the one before. From the order of those edges it decodes the kind of cycle in progress: row activation followed by reads or writes (including several column accesses under one row, page style), refresh by row strobe only, refresh with the column strobe first, or entry into a latched compressed test mode.

In the compressed test mode three column bits (the two lowest and the highest) are ignored. Each data pin therefore covers eight cells. A write copies each pin's bit into all eight of its cells. A read returns, per pin, a one when the eight cells agree and a zero when they do not. Reads in this mode take a configurable number of extra cycles. Status outputs show the test-mode flag, the last decoded cycle type and an illegal-sequence flag.

Top module: `dram_ptest_model`

## Requirements
- R1: After reset, dq_oe, test_mode and cyc_err are 0, cyc_type is 0 (idle), and every cell reads back as 0.
- R2: A column-strobe fall with WE high while a row is open is a read: cyc_type becomes 2, and dq_oe rises with the addressed word on dq_out exactly RD_LAT clock samples after the sample that saw the fall. The data stays driven after the column strobe rises and is withdrawn once both strobes are sampled high. A column-strobe fall with WE low is a write (cyc_type 3), stores dq_in and leaves the driver off.
- R3: While the row strobe stays low, each further column-strobe fall is a new access to the same row at the column now on addr, for both writes and reads.
- R4: A row-strobe fall while the column strobe is already low and WE is low in that sample and in the one before sets test_mode (cyc_type 6). test_mode then stays set across any number of ordinary cycles, and the driver stays off during the entry.
- R5: A column-first refresh with WE high clears test_mode, sets cyc_type to 5, and does not enable the driver.
- R6: Opening a row (cyc_type 1) and closing it with no column-strobe fall is a row-only refresh: it sets cyc_type 4 and clears test_mode.
- R7: In test mode a write stores dq_in into all eight words of the open row whose column bits [COL_W-2:2] match addr. No other word changes.
- R8: In test mode a read returns bit k = 1 when bit k of all eight words of the group is equal, and 0 otherwise, after RD_LAT+TM_LAT samples.
- R9: In test mode, column bits 0, 1 and COL_W-1 have no effect on which group a read selects.
- R10: A column-strobe pulse that falls and rises while the row strobe stays high, or a fall of both strobes in the same sample, sets cyc_err and cyc_type 7. The next legal row-strobe cycle clears cyc_err.
- R11: If WE is first seen low in the same sample as the row-strobe fall of a column-first cycle, the cycle is an ordinary refresh (cyc_type 5) and test_mode is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Data written by the controller |
| dq_out | output | DQ_W | Data driven by the model |
| dq_oe | output | 1 | Drive enable for dq_out |
| test_mode | output | 1 | Compressed test mode latched |
| cyc_type | output | 3 | Last decoded cycle: 0 idle, 1 row open, 2 read, 3 write, 4 row-only refresh, 5 column-first refresh, 6 test entry, 7 illegal |
| cyc_err | output | 1 | Illegal strobe sequence seen |

## Verification
The assertions assume that each input changes at most once per clock period, away from the sampling edge. They also assume that all inputs sit at their idle levels (strobes and WE high) while reset is held, so edge detection starts from a known history. The bench drives every input on the falling clock edge and holds each strobe level for at least one full sample. It lowers WE together with the column strobe, one sample ahead of the row strobe, whenever it means to enter test mode. The only deliberate breaks of the sequence rules are the illegal-cycle and late-WE scenarios, and the properties are written to hold through those as well.

// File: rtl/dram_ptest_pkg.sv
package dram_ptest_pkg;

   typedef enum logic [2:0] {
      CYC_IDLE    = 3'd0,
      CYC_ROW     = 3'd1,
      CYC_READ    = 3'd2,
      CYC_WRITE   = 3'd3,
      CYC_RASONLY = 3'd4,
      CYC_CBR     = 3'd5,
      CYC_TENTRY  = 3'd6,
      CYC_ILLEGAL = 3'd7
   } cyc_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ROW,
      ST_CBR,
      ST_VOID
   } ras_st_e;

endpackage

// File: rtl/dram_strobe_decode.sv
module dram_strobe_decode
   import dram_ptest_pkg::*;
#(
   parameter int ROW_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [ROW_W-1:0] row_addr,
   output logic [ROW_W-1:0] row_q,
   output logic             acc_stb,
   output logic             acc_we,
   output logic             cas_fall,
   output logic             test_mode,
   output cyc_e             cyc_type,
   output logic             cyc_err
);

   logic    ras_q, cas_q, we_q;
   logic    cas_early, col_seen;
   ras_st_e st;
   logic    ras_fall, ras_rise, cas_rise;

   assign ras_fall = ras_q & ~ras_n;
   assign ras_rise = ~ras_q & ras_n;
   assign cas_fall = cas_q & ~cas_n;
   assign cas_rise = ~cas_q & cas_n;
   assign acc_stb  = (st == ST_ROW) & ~ras_n & cas_fall;
   assign acc_we   = ~we_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_q     <= 1'b1;
         cas_q     <= 1'b1;
         we_q      <= 1'b1;
         cas_early <= 1'b0;
         col_seen  <= 1'b0;
         st        <= ST_IDLE;
         row_q     <= '0;
         test_mode <= 1'b0;
         cyc_type  <= CYC_IDLE;
         cyc_err   <= 1'b0;
      end else begin
         ras_q <= ras_n;
         cas_q <= cas_n;
         we_q  <= we_n;
         if (cas_fall && ras_n)
            cas_early <= 1'b1;
         if (ras_fall) begin
            cas_early <= 1'b0;
            if (cas_fall) begin
               st       <= ST_VOID;
               cyc_type <= CYC_ILLEGAL;
               cyc_err  <= 1'b1;
            end else if (!cas_n) begin
               st      <= ST_CBR;
               cyc_err <= 1'b0;
               if (!we_n && !we_q) begin
                  test_mode <= 1'b1;
                  cyc_type  <= CYC_TENTRY;
               end else begin
                  test_mode <= 1'b0;
                  cyc_type  <= CYC_CBR;
               end
            end else begin
               st       <= ST_ROW;
               row_q    <= row_addr;
               col_seen <= 1'b0;
               cyc_type <= CYC_ROW;
               cyc_err  <= 1'b0;
            end
         end else if (ras_rise) begin
            if (st == ST_ROW && !col_seen) begin
               test_mode <= 1'b0;
               cyc_type  <= CYC_RASONLY;
            end
            st <= ST_IDLE;
         end else if (acc_stb) begin
            col_seen <= 1'b1;
            cyc_type <= we_n ? CYC_READ : CYC_WRITE;
         end
         if (cas_rise && ras_n && cas_early) begin
            cas_early <= 1'b0;
            cyc_err   <= 1'b1;
            cyc_type  <= CYC_ILLEGAL;
         end
      end
   end

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
   parameter int ROW_W = 2,
   parameter int COL_W = 4,
   parameter int DQ_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             test_mode,
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   input  logic [DQ_W-1:0]  wr_data,
   output logic [DQ_W-1:0]  rd_data
);

   localparam int IDX_W = ROW_W + COL_W;
   localparam int WORDS = 1 << IDX_W;
   localparam int GROUP = 8;

   logic [DQ_W-1:0]  mem [WORDS];
   logic [WORDS-1:0] hit;
   logic [DQ_W-1:0]  cmp;

   if (COL_W < 4) begin : g_col_chk
      $error("dram_cell_array: COL_W must be at least 4");
   end
   if (IDX_W > 12) begin : g_size_chk
      $error("dram_cell_array: array too large for a model");
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_hit
      localparam logic [IDX_W-1:0] WI = IDX_W'(w);
      assign hit[w] = test_mode
         ? ((WI[IDX_W-1:COL_W] == row) && (WI[COL_W-2:2] == col[COL_W-2:2]))
         : (WI == {row, col});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else if (wr_en) begin
         for (int w = 0; w < WORDS; w++)
            if (hit[w]) mem[w] <= wr_data;
      end
   end

   always_comb begin
      logic [IDX_W-1:0] idx;
      logic [2:0]       jj;
      logic             all1, all0;
      idx = '0;
      jj  = '0;
      for (int k = 0; k < DQ_W; k++) begin
         all1 = 1'b1;
         all0 = 1'b1;
         for (int j = 0; j < GROUP; j++) begin
            jj   = 3'(j);
            idx  = {row, jj[2], col[COL_W-2:2], jj[1:0]};
            all1 = all1 & mem[idx][k];
            all0 = all0 & ~mem[idx][k];
         end
         cmp[k] = all1 | all0;
      end
   end

   assign rd_data = test_mode ? cmp : mem[{row, col}];

endmodule

// File: rtl/dram_dq_driver.sv
module dram_dq_driver #(
   parameter int DQ_W     = 4,
   parameter int RD_LAT   = 3,
   parameter int TM_LAT   = 2,
   parameter bit HOLD_EDO = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ras_n,
   input  logic            cas_n,
   input  logic            acc_stb,
   input  logic            acc_we,
   input  logic            cas_fall,
   input  logic            test_mode,
   input  logic [DQ_W-1:0] rd_data,
   output logic [DQ_W-1:0] dq_out,
   output logic            dq_oe
);

   localparam int LAT_MAX = RD_LAT + TM_LAT;
   localparam int CNT_W   = $clog2(LAT_MAX + 1);

   logic [CNT_W-1:0] cnt;
   logic             pend;
   logic [DQ_W-1:0]  hold;
   logic             release_now;

   if (RD_LAT < 1) begin : g_lat_chk
      $error("dram_dq_driver: RD_LAT must be at least 1");
   end

   if (HOLD_EDO) begin : g_edo
      assign release_now = ras_n & cas_n;
   end else begin : g_fpm
      assign release_now = cas_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dq_oe  <= 1'b0;
         dq_out <= '0;
         pend   <= 1'b0;
         cnt    <= '0;
         hold   <= '0;
      end else if (release_now || (cas_fall && acc_we)) begin
         dq_oe <= 1'b0;
         pend  <= 1'b0;
      end else if (acc_stb) begin
         hold <= rd_data;
         pend <= 1'b1;
         cnt  <= test_mode ? CNT_W'(LAT_MAX) : CNT_W'(RD_LAT);
      end else if (pend) begin
         if (cnt == CNT_W'(1)) begin
            dq_out <= hold;
            dq_oe  <= 1'b1;
            pend   <= 1'b0;
         end else begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/dram_ptest_model.sv
module dram_ptest_model
   import dram_ptest_pkg::*;
#(
   parameter int ROW_W    = 2,
   parameter int COL_W    = 4,
   parameter int DQ_W     = 4,
   parameter int RD_LAT   = 3,
   parameter int TM_LAT   = 2,
   parameter bit HOLD_EDO = 1'b1,
   localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic [DQ_W-1:0]   dq_out,
   output logic              dq_oe,
   output logic              test_mode,
   output logic [2:0]        cyc_type,
   output logic              cyc_err
);

   logic [ROW_W-1:0] row_q;
   logic             acc_stb, acc_we, cas_fall;
   logic [DQ_W-1:0]  rd_data;
   cyc_e             cyc_q;

   dram_strobe_decode #(.ROW_W(ROW_W)) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .row_addr  (addr[ROW_W-1:0]),
      .row_q     (row_q),
      .acc_stb   (acc_stb),
      .acc_we    (acc_we),
      .cas_fall  (cas_fall),
      .test_mode (test_mode),
      .cyc_type  (cyc_q),
      .cyc_err   (cyc_err)
   );

   dram_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (acc_stb & acc_we),
      .test_mode (test_mode),
      .row       (row_q),
      .col       (addr[COL_W-1:0]),
      .wr_data   (dq_in),
      .rd_data   (rd_data)
   );

   dram_dq_driver #(
      .DQ_W(DQ_W), .RD_LAT(RD_LAT), .TM_LAT(TM_LAT), .HOLD_EDO(HOLD_EDO)
   ) u_driver (
      .clk       (clk),
      .rst_n     (rst_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .acc_stb   (acc_stb),
      .acc_we    (acc_we),
      .cas_fall  (cas_fall),
      .test_mode (test_mode),
      .rd_data   (rd_data),
      .dq_out    (dq_out),
      .dq_oe     (dq_oe)
   );

   assign cyc_type = cyc_q;

endmodule

// File: rtl/dram_ptest_sva.sv
module dram_ptest_sva (
   input logic clk,
   input logic rst_n,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic dq_oe,
   input logic test_mode,
   input logic cyc_err
);

   // R2: the driver is never on in a sample that follows both strobes high
   assert_oe_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !($past(ras_n) && $past(cas_n)));

   // R2: a write-type column strobe fall turns the driver off
   assert_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && $past(cas_n) && !we_n) |=> !dq_oe);

   // R4: test mode is set only after a sample with all three strobes low
   assert_tm_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_mode) |-> $past(!ras_n && !cas_n && !we_n));

   // R5 / R6: test mode is cleared only on a row strobe edge
   assert_tm_exit_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(test_mode) |-> ($past(ras_n) != $past(ras_n, 2)));

   // R10: the error flag rises only on a column strobe edge
   assert_err_on_cas_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cyc_err) |-> ($past(cas_n) != $past(cas_n, 2)));

endmodule

bind dram_ptest_model dram_ptest_sva u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .dq_oe     (dq_oe),
   .test_mode (test_mode),
   .cyc_err   (cyc_err)
);

// File: tb/dram_ptest_model_tb.sv
module dram_ptest_model_tb;

   localparam int ROW_W  = 2;
   localparam int COL_W  = 4;
   localparam int DQ_W   = 4;
   localparam int RD_LAT = 3;
   localparam int TM_LAT = 2;
   localparam int ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ras_n = 1'b1;
   logic              cas_n = 1'b1;
   logic              we_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [DQ_W-1:0]   dq_in = '0;
   logic [DQ_W-1:0]   dq_out;
   logic              dq_oe;
   logic              test_mode;
   logic [2:0]        cyc_type;
   logic              cyc_err;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   dram_ptest_model #(
      .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
      .RD_LAT(RD_LAT), .TM_LAT(TM_LAT), .HOLD_EDO(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .test_mode(test_mode), .cyc_type(cyc_type), .cyc_err(cyc_err)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic write_cyc(input logic [3:0] row, input logic [3:0] col, input logic [3:0] data);
      addr = row; ras_n = 1'b0; tick(1);
      addr = col; dq_in = data; we_n = 1'b0; cas_n = 1'b0; tick(1);
      chk("R2 write cycle type", cyc_type, 3'd3);
      chk("R2 write keeps driver off", dq_oe, 1'b0);
      cas_n = 1'b1; we_n = 1'b1; tick(1);
      ras_n = 1'b1; tick(1);
   endtask

   task automatic read_chk(input string tag, input logic [3:0] row, input logic [3:0] col,
                           input logic [3:0] exp, input int lat);
      addr = row; ras_n = 1'b0; tick(1);
      addr = col; cas_n = 1'b0; tick(lat);
      chk({tag, " driver still off before latency"}, dq_oe, 1'b0);
      chk("R2 read cycle type", cyc_type, 3'd2);
      tick(1);
      chk({tag, " driver on at latency"}, dq_oe, 1'b1);
      chk({tag, " read data"}, dq_out, exp);
      cas_n = 1'b1; tick(2);
      chk("R2 data held after column strobe rises", {dq_oe, dq_out}, {1'b1, exp});
      ras_n = 1'b1; tick(1);
      chk("R2 driver released with both strobes high", dq_oe, 1'b0);
      tick(1);
   endtask

   task automatic col_first(input bit we_low);
      cas_n = 1'b0; we_n = !we_low; tick(1);
      ras_n = 1'b0; tick(1);
   endtask

   task automatic col_first_end();
      ras_n = 1'b1; tick(1);
      cas_n = 1'b1; we_n = 1'b1; tick(1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(1);
      chk("R1 reset dq_oe", dq_oe, 1'b0);
      chk("R1 reset test_mode", test_mode, 1'b0);
      chk("R1 reset cyc_err", cyc_err, 1'b0);
      chk("R1 reset cyc_type", cyc_type, 3'd0);
      read_chk("R1 cleared cell", 4'd2, 4'd9, 4'h0, RD_LAT);
   endtask

   task automatic t_normal();
      write_cyc(4'd1, 4'd3, 4'h6);
      read_chk("R2 normal", 4'd1, 4'd3, 4'h6, RD_LAT);
   endtask

   task automatic t_page();
      addr = 4'd3; ras_n = 1'b0; tick(1);
      addr = 4'd2; dq_in = 4'h5; we_n = 1'b0; cas_n = 1'b0; tick(1);
      cas_n = 1'b1; tick(1);
      addr = 4'd9; dq_in = 4'hC; cas_n = 1'b0; tick(1);
      chk("R3 second page write type", cyc_type, 3'd3);
      cas_n = 1'b1; we_n = 1'b1; tick(1);
      ras_n = 1'b1; tick(1);
      addr = 4'd3; ras_n = 1'b0; tick(1);
      addr = 4'd2; cas_n = 1'b0; tick(RD_LAT + 1);
      chk("R3 page read first column", dq_out, 4'h5);
      cas_n = 1'b1; tick(1);
      addr = 4'd9; cas_n = 1'b0; tick(RD_LAT + 1);
      chk("R3 page read second column", {dq_oe, dq_out}, {1'b1, 4'hC});
      ras_n = 1'b1; cas_n = 1'b1; tick(2);
   endtask

   task automatic t_test_entry();
      col_first(1'b1);
      chk("R4 test entry sets test_mode", test_mode, 1'b1);
      chk("R4 test entry cycle type", cyc_type, 3'd6);
      chk("R4 test entry leaves driver off", dq_oe, 1'b0);
      col_first_end();
   endtask

   task automatic t_test_access();
      t_test_entry();
      write_cyc(4'd1, 4'b0100, 4'hA);
      chk("R4 test mode latched across write", test_mode, 1'b1);
      read_chk("R8 all agree", 4'd1, 4'b1111, 4'hF, RD_LAT + TM_LAT);
      chk("R4 test mode latched across read", test_mode, 1'b1);
      col_first(1'b0);
      chk("R5 refresh clears test_mode", test_mode, 1'b0);
      chk("R5 refresh cycle type", cyc_type, 3'd5);
      chk("R5 refresh leaves driver off", dq_oe, 1'b0);
      col_first_end();
      write_cyc(4'd1, 4'd5, 4'hB);
      t_test_entry();
      read_chk("R8 one pin disagrees", 4'd1, 4'b0100, 4'hE, RD_LAT + TM_LAT);
      read_chk("R9 ignored column bits", 4'd1, 4'b1001, 4'h9, RD_LAT + TM_LAT);
      addr = 4'd0; ras_n = 1'b0; tick(1);
      chk("R6 row open cycle type", cyc_type, 3'd1);
      ras_n = 1'b1; tick(1);
      chk("R6 row-only refresh clears test_mode", test_mode, 1'b0);
      chk("R6 row-only refresh cycle type", cyc_type, 3'd4);
      tick(1);
      read_chk("R7 group member written", 4'd1, 4'd14, 4'hA, RD_LAT);
      read_chk("R7 later normal write kept", 4'd1, 4'd5, 4'hB, RD_LAT);
      read_chk("R7 other group untouched", 4'd1, 4'd3, 4'h6, RD_LAT);
      read_chk("R7 other row untouched", 4'd0, 4'd4, 4'h0, RD_LAT);
   endtask

   task automatic t_late_we();
      t_test_entry();
      cas_n = 1'b0; tick(1);
      ras_n = 1'b0; we_n = 1'b0; tick(1);
      chk("R11 late WE is plain refresh", cyc_type, 3'd5);
      chk("R11 late WE clears test_mode", test_mode, 1'b0);
      col_first_end();
   endtask

   task automatic t_illegal();
      cas_n = 1'b0; tick(1);
      cas_n = 1'b1; tick(1);
      chk("R10 lone column pulse flags error", {cyc_err, cyc_type}, {1'b1, 3'd7});
      chk("R10 lone column pulse driver off", dq_oe, 1'b0);
      addr = 4'd2; ras_n = 1'b0; tick(1);
      chk("R10 legal cycle clears error", cyc_err, 1'b0);
      ras_n = 1'b1; tick(1);
      ras_n = 1'b0; cas_n = 1'b0; tick(1);
      chk("R10 both strobes together flag error", {cyc_err, cyc_type}, {1'b1, 3'd7});
      tick(1);
      chk("R10 both strobes together driver off", dq_oe, 1'b0);
      ras_n = 1'b1; cas_n = 1'b1; tick(2);
   endtask

   initial begin
      t_reset();
      t_normal();
      t_page();
      t_test_access();
      t_late_we();
      t_illegal();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule